// File: doc/BRIEF.md
# Multiword Carry-Chain Adder Unit

This unit adds 64-bit words so that sums wider than one register can be built from ordinary general registers. There is no flags register. The carry of each word travels in a register: either as the result of a carry-generate operation, or as the high word of a double-width destination. That high word is then fed back as the third operand of the add for the next word up.

Each accepted request supplies three operands and a 2-bit opcode. The unit returns, one clock later, a low result word and a high result word, each with its own write-enable. It also returns a signed-overflow flag for the word just summed, which gives the sign test for the top word of a chain. Register-file write ports and forwarding lie outside the block: they appear only as the two result words and their enables.

Top module: `mwadd_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted request, every output is zero: both result words, both write-enables and the overflow flag.
- R2: Opcode 2'b00 (three-input add) returns the low 64 bits of a+b+c on the low word. It raises only the low write-enable, and the high word is 0.
- R3: Opcode 2'b01 (carry-generate) computes a+b+c and returns only its carry-out (0, 1 or 2) as an unsigned integer in the low word. It raises only the low write-enable, and the high word is 0.
- R4: Opcode 2'b10 (double add of two inputs) returns the low 64 bits of a+b on the low word and the carry (0 or 1) on the high word. Operand c has no effect. Both write-enables rise in the same cycle.
- R5: Opcode 2'b11 (double add of three inputs) returns the low 64 bits of a+b+c on the low word and the carry (0, 1 or 2) on the high word. Both write-enables rise.
- R6: Bits 63 down to 2 of the high word are always 0.
- R7: The overflow flag is bit 63 of ((s XOR a) AND (s XOR b)), where s is the low result word of a summing opcode (00, 10, 11). The flag is 0 for carry-generate.
- R8: Results appear exactly one cycle after a cycle in which the input is valid. In a cycle after an idle input, both write-enables are 0 and the result words and overflow flag keep their previous values.
- R9: A 256-bit sum built as one 2-input double add followed by three 3-input double adds, each taking the previous high word as c, matches the 257-bit sum: four low words plus a final carry that is nonzero exactly when the top high word is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid this cycle |
| in_op | input | 2 | Opcode: 00 add3, 01 carry-generate, 10 double add2, 11 double add3 |
| in_a | input | 64 | Operand a |
| in_b | input | 64 | Operand b |
| in_c | input | 64 | Operand c (carry-in word or zero) |
| res_lo | output | 64 | Low result word |
| res_hi | output | 64 | High result word (carry, zero-extended) |
| we_lo | output | 1 | Write-enable for the low destination |
| we_hi | output | 1 | Write-enable for the high destination |
| sovf | output | 1 | Signed overflow of the summed word |

## Verification
The vector table runs every opcode with small operands, giving carry 0. It also runs operands of all ones, giving carry 2, and pairs of sign bits, giving carry 1. This separates a carry count from a carry bit and a two-input path from a three-input one. The double add of two inputs is given a nonzero c to show that c is ignored. The overflow flag is tried at the positive-to-negative boundary, at the negative boundary and with mixed signs. A chained 256-bit sum with carries crossing several limbs is then compared against a wide sum computed in the bench, and idle cycles check that the write-enables drop while the result words hold.

// File: rtl/mwadd_pkg.sv
package mwadd_pkg;
  typedef enum logic [1:0] {
    OP_ADD3   = 2'b00,
    OP_CGEN   = 2'b01,
    OP_DADD2  = 2'b10,
    OP_DADD3  = 2'b11
  } mwadd_op_e;

  localparam int unsigned CARRY_W = 2;
endpackage

// File: rtl/mwadd_sum3.sv
module mwadd_sum3 import mwadd_pkg::*; #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic [W-1:0]       c,
  input  logic               use_c,
  output logic [W-1:0]       sum,
  output logic [CARRY_W-1:0] carry
);
  localparam int unsigned XW = W + CARRY_W;

  logic [W-1:0]  c_g;
  logic [XW-1:0] wide;

  always_comb begin
    c_g  = use_c ? c : '0;
    wide = {{CARRY_W{1'b0}}, a} + {{CARRY_W{1'b0}}, b} + {{CARRY_W{1'b0}}, c_g};
    sum   = wide[W-1:0];
    carry = wide[XW-1:W];
  end
endmodule

// File: rtl/mwadd_ovf.sv
module mwadd_ovf #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] s,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         ovf
);
  logic [W-1:0] mix;

  always_comb begin
    mix = (s ^ a) & (s ^ b);
    ovf = mix[W-1];
  end
endmodule

// File: rtl/mwadd_unit.sv
module mwadd_unit import mwadd_pkg::*; #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   in_op,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] res_lo,
  output logic [W-1:0] res_hi,
  output logic         we_lo,
  output logic         we_hi,
  output logic         sovf
);
  localparam int unsigned PADW = W - CARRY_W;

  mwadd_op_e          op;
  logic               use_c;
  logic [W-1:0]       sum;
  logic [CARRY_W-1:0] carry;
  logic               ovf_raw;

  logic [W-1:0]       lo_d, hi_d;
  logic               welo_d, wehi_d, ovf_d;
  logic [W-1:0]       lo_q, hi_q;
  logic               welo_q, wehi_q, ovf_q;
  logic               data_en;

  assign op    = mwadd_op_e'(in_op);
  assign use_c = (op != OP_DADD2);

  mwadd_sum3 #(.W(W)) sum_i (
    .a(in_a), .b(in_b), .c(in_c), .use_c(use_c),
    .sum(sum), .carry(carry)
  );

  mwadd_ovf #(.W(W)) ovf_i (
    .s(sum), .a(in_a), .b(in_b), .ovf(ovf_raw)
  );

  // next-state
  always_comb begin
    data_en = in_valid;
    welo_d  = in_valid;
    wehi_d  = in_valid && in_op[1];
    ovf_d   = ovf_q;
    lo_d    = lo_q;
    hi_d    = hi_q;
    if (in_valid) begin
      unique case (op)
        OP_ADD3: begin
          lo_d  = sum;
          hi_d  = '0;
          ovf_d = ovf_raw;
        end
        OP_CGEN: begin
          lo_d  = {{PADW{1'b0}}, carry};
          hi_d  = '0;
          ovf_d = 1'b0;
        end
        default: begin
          lo_d  = sum;
          hi_d  = {{PADW{1'b0}}, carry};
          ovf_d = ovf_raw;
        end
      endcase
    end
  end

  // enables, cleared every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      welo_q <= 1'b0;
      wehi_q <= 1'b0;
    end else begin
      welo_q <= welo_d;
      wehi_q <= wehi_d;
    end
  end

  // data, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ovf_q <= 1'b0;
    end else if (data_en) begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      ovf_q <= ovf_d;
    end
  end

  assign res_lo = lo_q;
  assign res_hi = hi_q;
  assign we_lo  = welo_q;
  assign we_hi  = wehi_q;
  assign sovf   = ovf_q;
endmodule

// File: rtl/mwadd_chk.sv
module mwadd_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   in_op,
  input logic [W-1:0] res_lo,
  input logic [W-1:0] res_hi,
  input logic         we_lo,
  input logic         we_hi,
  input logic         sovf
);
  // R8
  valid_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> we_lo);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!we_lo && !we_hi && $stable(res_lo) && $stable(res_hi) && $stable(sovf)));

  // R4
  dual_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op[1]) |=> (we_lo && we_hi));

  // R2
  single_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op[1]) |=> (!we_hi && res_hi == '0));

  // R3
  cgen_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01) |=> (res_lo[W-1:2] == '0 && !sovf));

  // R6
  hi_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_hi[W-1:2] == '0);

  // R1
  reset_we_chk: assert property (@(posedge clk)
    !rst_n |-> (!we_lo && !we_hi));
endmodule

bind mwadd_unit mwadd_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .res_lo(res_lo), .res_hi(res_hi), .we_lo(we_lo), .we_hi(we_hi), .sovf(sovf)
);

// File: tb/mwadd_unit_tb_top.sv
module mwadd_unit_tb_top;
  localparam int W  = 64;
  localparam int NV = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;

  localparam logic [1:0]  V_OP  [NV] = '{2'b00, 2'b00, 2'b01, 2'b01, 2'b01,
                                         2'b10, 2'b10, 2'b11, 2'b11, 2'b00};
  localparam logic [63:0] V_A   [NV] = '{64'd1, ONES, ONES, 64'd1, MSB,
                                         ONES, MAXP, ONES, MSB, MSB};
  localparam logic [63:0] V_B   [NV] = '{64'd2, ONES, ONES, 64'd2, MSB,
                                         64'd1, 64'd1, ONES, MSB, 64'd0};
  localparam logic [63:0] V_C   [NV] = '{64'd3, ONES, ONES, 64'd3, 64'd0,
                                         ONES, 64'd5, 64'd2, 64'd0, MSB};
  localparam logic [63:0] V_LO  [NV] = '{64'd6, 64'hFFFF_FFFF_FFFF_FFFD, 64'd2, 64'd0, 64'd1,
                                         64'd0, MSB, 64'd0, 64'd0, 64'd0};
  localparam logic [63:0] V_HI  [NV] = '{64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
                                         64'd1, 64'd0, 64'd2, 64'd1, 64'd0};
  localparam logic        V_OVF [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                         1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam string       V_REQ [NV] = '{"R2", "R2", "R3", "R3", "R3",
                                         "R4", "R7", "R5", "R5", "R7"};

  logic         clk, rst_n, in_valid;
  logic [1:0]   in_op;
  logic [W-1:0] in_a, in_b, in_c;
  logic [W-1:0] res_lo, res_hi;
  logic         we_lo, we_hi, sovf;

  int n_chk, n_bad;

  mwadd_unit #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .res_lo(res_lo), .res_hi(res_hi), .we_lo(we_lo), .we_hi(we_hi), .sovf(sovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic issue(input logic [1:0] op, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] c);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_c = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [255:0] ba, bb;
    logic [256:0] ref_sum;
    logic [63:0]  carry_w, held_lo;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_op = 2'b00;
    in_a = '0; in_b = '0; in_c = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "res_lo", res_lo, 64'd0);
    check("R1", "res_hi", res_hi, 64'd0);
    check("R1", "we", {62'd0, we_hi, we_lo}, 64'd0);
    check("R1", "sovf", {63'd0, sovf}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "we after release", {62'd0, we_hi, we_lo}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      issue(V_OP[i], V_A[i], V_B[i], V_C[i]);
      check(V_REQ[i], "res_lo", res_lo, V_LO[i]);
      check(V_REQ[i], "res_hi", res_hi, V_HI[i]);
      check(V_REQ[i], "sovf", {63'd0, sovf}, {63'd0, V_OVF[i]});
      check(V_REQ[i], "we_lo", {63'd0, we_lo}, 64'd1);
      check(V_REQ[i], "we_hi", {63'd0, we_hi}, {63'd0, V_OP[i][1]});
      // R6 padding of the high word
      check("R6", "res_hi pad", {2'b00, res_hi[63:2]}, 64'd0);
    end

    // R8 idle cycle: enables drop, data held
    held_lo = res_lo;
    @(negedge clk);
    check("R8", "we idle", {62'd0, we_hi, we_lo}, 64'd0);
    check("R8", "res_lo held", res_lo, held_lo);

    // R4 c ignored: same a,b different c
    issue(2'b10, 64'd10, 64'd20, 64'd12345);
    check("R4", "c ignored lo", res_lo, 64'd30);
    check("R4", "c ignored hi", res_hi, 64'd0);

    // R9 256-bit chain
    ba = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF0};
    bb = {64'h8000_0000_0000_0001, 64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0020};
    ref_sum = {1'b0, ba} + {1'b0, bb};
    issue(2'b10, ba[63:0], bb[63:0], ONES);
    check("R9", "limb0", res_lo, ref_sum[63:0]);
    carry_w = res_hi;
    for (int k = 1; k < 4; k++) begin
      issue(2'b11, ba[k*64 +: 64], bb[k*64 +: 64], carry_w);
      check("R9", "limb", res_lo, ref_sum[k*64 +: 64]);
      carry_w = res_hi;
    end
    check("R9", "final carry", {63'd0, carry_w != 64'd0}, {63'd0, ref_sum[256]});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule